// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is a single timer channel. Once enabled it loads a programmable reload value and counts down by one on each selected tick, either a fixed 1 MHz strobe or a bus-clock strobe. Two match registers can be programmed in any order. As the count falls through the larger match, then the smaller match, and finally zero, the channel raises interrupt events. When the count has reached zero, the next tick restarts it from the reload value.

Each event inverts a level-style interrupt line and produces a one-cycle pulse. The shared status register uses that pulse to flag the channel. Bus decode, the shared control word and pulse-output mode belong to the surrounding logic. The channel takes its enable, clock select and overflow-enable as plain inputs. It takes register writes as strobes that share one data bus.

Top module: `dmatch_timer`

## Requirements
- R1: After synchronous reset the reload register, both match registers, the interrupt level and the event pulse are all zero, so `count_q` reads 0.
- R2: While running, the count drops by one on each cycle where the selected tick strobe is high. `tick_ext` is selected when `use_ext_tick` is 1 and `tick_bus` when it is 0. The unselected strobe has no effect.
- R3: On the first clock edge with `enable` high after it was low, the count is loaded with the reload value. This happens regardless of the count left over from an earlier run.
- R4: While `enable` is low, `count_q` shows the reload register, not the live count.
- R5: A tick that finds the count at zero reloads it from the reload register, and that tick raises no event.
- R6: A match value greater than or equal to the reload value behaves as a match at zero.
- R7: A tick that moves the count onto either effective match value raises an event. With distinct matches the events come at the larger value first, then the smaller, whichever register holds which.
- R8: A tick that moves the count onto zero raises an event only if `ovf_irq_en` is 1 or an effective match is zero. Coinciding matches, or a match at zero, give a single event.
- R9: Each event inverts `irq_level` and drives `event_pulse` high for exactly that one cycle, in the same cycle as the inversion. At all other times `irq_level` holds.
- R10: Writing the count register while running loads the written value into the count. This write takes priority over a tick in the same cycle.
- R11: Writing a nonzero value to the reload register while it holds zero and the timer is running starts the count from the written value. A reload write over a nonzero reload leaves the current count untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel run enable |
| use_ext_tick | input | 1 | 1 selects the 1 MHz tick, 0 the bus-clock tick |
| ovf_irq_en | input | 1 | Allows an event when the count reaches zero |
| tick_ext | input | 1 | Fixed 1 MHz tick strobe |
| tick_bus | input | 1 | Bus-clock tick strobe |
| wr_count | input | 1 | Write strobe for the current count |
| wr_reload | input | 1 | Write strobe for the reload register |
| wr_match_a | input | 1 | Write strobe for the first match register |
| wr_match_b | input | 1 | Write strobe for the second match register |
| wr_data | input | CNT_W | Data for all register writes |
| count_q | output | CNT_W | Live count while running, reload value otherwise |
| irq_level | output | 1 | Interrupt line, inverted on every event |
| event_pulse | output | 1 | One-cycle pulse per event for the shared status register |

## Verification
Every result here is registered exactly once. The count, `irq_level` and `event_pulse` all change on the edge that samples the tick, enable or write, so each result is due one cycle after its stimulus. The bench drives inputs on the falling edge and reads outputs on the next falling edge, one rising edge later, and compares against an arithmetic model of that single step. The sweep over every pair of match values and both overflow settings checks each step of a full countdown and its wrap. Each step's count, pulse and interrupt inversion are checked in the cycle they are due.

// File: rtl/dmt_pkg.sv
// Shared definitions for the dual-match timer channel.
// Assumes: exactly two match registers per channel.
package dmt_pkg;
    localparam int NUM_MATCH = 2;

    // Action applied to the count register on the next edge.
    typedef enum logic [1:0] {
        CNT_HOLD   = 2'd0,
        CNT_RELOAD = 2'd1,
        CNT_LOAD   = 2'd2,
        CNT_STEP   = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/dmt_tick_sel.sv
// Picks the tick strobe that advances the count.
// Assumes: both strobes are synchronous to clk, one cycle wide per tick.
module dmt_tick_sel (
    input  logic use_ext_i,
    input  logic tick_ext_i,
    input  logic tick_bus_i,
    output logic tick_o
);
    // Select fixed-rate strobe or bus strobe.
    always_comb tick_o = use_ext_i ? tick_ext_i : tick_bus_i;
endmodule

// File: rtl/dmt_match_cmp.sv
// Clamps each match value against the reload value and flags whether the
// count value about to be entered is an event point.
// Assumes: target_i is the value the count would take after one step.
module dmt_match_cmp #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic [N-1:0][W-1:0] match_i,
    input  logic [W-1:0]        reload_i,
    input  logic [W-1:0]        target_i,
    input  logic                ovf_en_i,
    output logic                hit_o
);
    logic [N-1:0]        hit_vec;
    logic [N-1:0][W-1:0] eff;

    for (genvar g = 0; g < N; g++) begin : g_match
        // Matches at or beyond the reload point collapse onto zero.
        always_comb eff[g] = (match_i[g] >= reload_i) ? '0 : match_i[g];
        // Compare the clamped match with the next count.
        always_comb hit_vec[g] = (target_i == eff[g]);
    end

    // Any match hit or a permitted zero arrival is one event.
    always_comb hit_o = (|hit_vec) || (ovf_en_i && (target_i == '0));
endmodule

// File: rtl/dmt_count_ctl.sv
// Holds the down-count and decides on each edge whether to hold, reload,
// take written data or step. Flags a step that lands on an event point.
// Assumes: match_hit_i is evaluated against next_o.
module dmt_count_ctl
    import dmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         tick_i,
    input  logic         wr_count_i,
    input  logic         reload_start_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] reload_i,
    input  logic         match_hit_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] next_o,
    output logic         running_o,
    output logic         step_event_o
);
    cnt_op_e op;

    // Enable seen on the previous edge; marks a running channel.
    always_ff @(posedge clk) begin
        if (!rst_n) running_o <= 1'b0;
        else        running_o <= enable_i;
    end

    // Priority: start, count write, reload-start, tick.
    always_comb begin
        if (!enable_i)            op = CNT_HOLD;
        else if (!running_o)      op = CNT_RELOAD;
        else if (wr_count_i)      op = CNT_LOAD;
        else if (reload_start_i)  op = CNT_LOAD;
        else if (!tick_i)         op = CNT_HOLD;
        else if (cnt_o == '0)     op = CNT_RELOAD;
        else                      op = CNT_STEP;
    end

    // Value one step down from the current count.
    always_comb next_o = cnt_o - W'(1);

    // Only a genuine step onto an event point counts.
    always_comb step_event_o = (op == CNT_STEP) && match_hit_i;

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else begin
            unique case (op)
                CNT_RELOAD: cnt_o <= reload_i;
                CNT_LOAD:   cnt_o <= wr_data_i;
                CNT_STEP:   cnt_o <= next_o;
                default:    cnt_o <= cnt_o;
            endcase
        end
    end
endmodule

// File: rtl/dmatch_timer.sv
// One down-counting timer channel with two unordered match points.
// Holds the reload and match registers, drives the toggling interrupt
// line and the one-cycle event pulse for the shared status register.
// Assumes: write strobes are one cycle wide and share wr_data.
module dmatch_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             use_ext_tick,
    input  logic             ovf_irq_en,
    input  logic             tick_ext,
    input  logic             tick_bus,
    input  logic             wr_count,
    input  logic             wr_reload,
    input  logic             wr_match_a,
    input  logic             wr_match_b,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_level,
    output logic             event_pulse
);
    logic [CNT_W-1:0]                reload_q;
    logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
    logic [NUM_MATCH-1:0]            match_wr;
    logic [CNT_W-1:0]                cnt_w;
    logic [CNT_W-1:0]                next_w;
    logic                            tick_w;
    logic                            hit_w;
    logic                            running_w;
    logic                            step_event_w;
    logic                            reload_start_w;

    always_comb match_wr = {wr_match_b, wr_match_a};

    // Reload register.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (wr_reload) reload_q <= wr_data;
    end

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_mreg
        // Match register g.
        always_ff @(posedge clk) begin
            if (!rst_n)           match_q[g] <= '0;
            else if (match_wr[g]) match_q[g] <= wr_data;
        end
    end

    // A first nonzero reload over zero restarts the count.
    always_comb reload_start_w = wr_reload && (reload_q == '0) && (wr_data != '0);

    dmt_tick_sel u_tick (
        .use_ext_i  (use_ext_tick),
        .tick_ext_i (tick_ext),
        .tick_bus_i (tick_bus),
        .tick_o     (tick_w)
    );

    dmt_match_cmp #(.W(CNT_W), .N(NUM_MATCH)) u_cmp (
        .match_i  (match_q),
        .reload_i (reload_q),
        .target_i (next_w),
        .ovf_en_i (ovf_irq_en),
        .hit_o    (hit_w)
    );

    dmt_count_ctl #(.W(CNT_W)) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable_i       (enable),
        .tick_i         (tick_w),
        .wr_count_i     (wr_count),
        .reload_start_i (reload_start_w),
        .wr_data_i      (wr_data),
        .reload_i       (reload_q),
        .match_hit_i    (hit_w),
        .cnt_o          (cnt_w),
        .next_o         (next_w),
        .running_o      (running_w),
        .step_event_o   (step_event_w)
    );

    // Interrupt level inverts and the status pulse fires on every event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level   <= 1'b0;
            event_pulse <= 1'b0;
        end else begin
            irq_level   <= irq_level ^ step_event_w;
            event_pulse <= step_event_w;
        end
    end

    // Visible count: live only once running, reload value otherwise.
    always_comb count_q = (enable && running_w) ? cnt_w : reload_q;
endmodule

// File: rtl/dmt_checker.sv
// Temporal checks for the timer channel, attached by bind.
module dmt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         running,
    input logic [W-1:0] cnt,
    input logic [W-1:0] reload_q,
    input logic         irq_level,
    input logic         event_pulse
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_level == 1'b0 && reload_q == '0 && !event_pulse));

    p_enable_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !running) |=> (cnt == $past(reload_q)));

    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(cnt));

    p_toggle_on_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> (irq_level != $past(irq_level)));

    p_quiet_no_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !event_pulse |-> $stable(irq_level));

    p_event_when_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> $past(running));
endmodule

bind dmatch_timer dmt_checker #(.W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .running     (running_w),
    .cnt         (cnt_w),
    .reload_q    (reload_q),
    .irq_level   (irq_level),
    .event_pulse (event_pulse)
);

// File: tb/dmatch_timer_tb.sv
module dmatch_timer_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, enable, use_ext_tick, ovf_irq_en, tick_ext, tick_bus;
    logic         wr_count, wr_reload, wr_match_a, wr_match_b;
    logic [W-1:0] wr_data, count_q;
    logic         irq_level, event_pulse;
    int           n_chk = 0;
    int           n_fail = 0;

    always #4 clk = ~clk;

    dmatch_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .use_ext_tick(use_ext_tick),
        .ovf_irq_en(ovf_irq_en), .tick_ext(tick_ext), .tick_bus(tick_bus),
        .wr_count(wr_count), .wr_reload(wr_reload), .wr_match_a(wr_match_a),
        .wr_match_b(wr_match_b), .wr_data(wr_data), .count_q(count_q),
        .irq_level(irq_level), .event_pulse(event_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // kind: 0 count, 1 reload, 2 match a, 3 match b
    task automatic wr(input int kind, input int data);
        wr_data    = W'(data);
        wr_count   = (kind == 0);
        wr_reload  = (kind == 1);
        wr_match_a = (kind == 2);
        wr_match_b = (kind == 3);
        cyc();
        {wr_count, wr_reload, wr_match_a, wr_match_b} = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; use_ext_tick = 1'b0; ovf_irq_en = 1'b0;
        tick_ext = 1'b0; tick_bus = 1'b0; wr_data = '0;
        {wr_count, wr_reload, wr_match_a, wr_match_b} = '0;
        @(negedge clk);
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        check("R1 count_q", int'(count_q), 0);
        check("R1 irq_level", int'(irq_level), 0);
        check("R1 event_pulse", int'(event_pulse), 0);

        // R5/R6/R7/R8/R9 sweep over every match pair and overflow setting
        begin
            int rl;
            rl = 6;
            for (int a = 0; a <= rl + 1; a++) begin
                for (int b = 0; b <= rl + 1; b++) begin
                    for (int ov = 0; ov < 2; ov++) begin
                        int ea, eb, expc, mism;
                        logic prev_irq, ev;
                        enable = 1'b0;
                        cyc();
                        wr(1, rl);
                        wr(2, a);
                        wr(3, b);
                        ovf_irq_en = ov[0];
                        ea = (a >= rl) ? 0 : a;
                        eb = (b >= rl) ? 0 : b;
                        enable = 1'b1;
                        cyc();
                        mism = 0;
                        expc = rl;
                        if (int'(count_q) != expc) mism++;
                        prev_irq = irq_level;
                        tick_bus = 1'b1;
                        for (int s = 0; s <= rl + 1; s++) begin
                            cyc();
                            if (expc == 0) begin
                                expc = rl;
                                ev = 1'b0;
                            end else begin
                                expc = expc - 1;
                                ev = (expc == ea) || (expc == eb) || (expc == 0 && ov == 1);
                            end
                            if (int'(count_q) != expc) mism++;
                            if (event_pulse !== ev) mism++;
                            if (irq_level !== (prev_irq ^ ev)) mism++;
                            prev_irq = irq_level;
                        end
                        tick_bus = 1'b0;
                        check($sformatf("R5/R6/R7/R8/R9 sweep a=%0d b=%0d ovf=%0d mismatches", a, b, ov),
                              mism, 0);
                    end
                end
            end
        end

        // R4 disabled read shows reload
        enable = 1'b0;
        ovf_irq_en = 1'b0;
        cyc();
        wr(2, 0);
        wr(3, 0);
        wr(1, 33);
        check("R4 disabled count_q", int'(count_q), 33);

        // R3 enable loads reload, then count, disable, re-enable
        enable = 1'b1;
        cyc();
        check("R3 first enabled count", int'(count_q), 33);
        tick_bus = 1'b1;
        repeat (5) cyc();
        tick_bus = 1'b0;
        check("R2 bus tick count", int'(count_q), 28);
        enable = 1'b0;
        cyc();
        check("R4 disabled after run", int'(count_q), 33);
        enable = 1'b1;
        cyc();
        check("R3 re-enable reloads", int'(count_q), 33);

        // R2 tick source selection
        use_ext_tick = 1'b1;
        tick_bus = 1'b1;
        repeat (3) cyc();
        check("R2 bus tick ignored in ext mode", int'(count_q), 33);
        tick_bus = 1'b0;
        tick_ext = 1'b1;
        repeat (2) cyc();
        check("R2 ext tick counts", int'(count_q), 31);
        use_ext_tick = 1'b0;
        repeat (3) cyc();
        tick_ext = 1'b0;
        check("R2 ext tick ignored in bus mode", int'(count_q), 31);

        // R10 count write beats a coincident tick
        tick_bus = 1'b1;
        wr(0, 7);
        check("R10 written count", int'(count_q), 7);
        cyc();
        tick_bus = 1'b0;
        check("R10 count steps after write", int'(count_q), 6);

        // R11 reload from zero starts counting
        enable = 1'b0;
        cyc();
        wr(1, 0);
        enable = 1'b1;
        cyc();
        check("R11 count with zero reload", int'(count_q), 0);
        begin
            logic irq0;
            irq0 = irq_level;
            tick_bus = 1'b1;
            repeat (3) cyc();
            tick_bus = 1'b0;
            check("R5 zero reload stays at zero", int'(count_q), 0);
            check("R5 no event from wrap", int'(irq_level), int'(irq0));
        end
        wr(1, 12);
        check("R11 nonzero reload starts count", int'(count_q), 12);
        tick_bus = 1'b1;
        cyc();
        tick_bus = 1'b0;
        wr(1, 20);
        check("R11 reload over nonzero keeps count", int'(count_q), 11);

        finish_run();
    end
endmodule